// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block deserialises one stereo PCM lane into parallel 24-bit left and right samples. It runs as a clock slave. The bit clock, the frame (word-select) clock and the serial data all come from outside. They are oversampled by a faster system clock, which also drives every register in the block. Each completed stereo frame appears on two sample buses, together with a one-cycle valid strobe.

A two-bit format selector picks one of three framings: I2S, MSB-first left-justified or MSB-first right-justified. A one-bit ratio selector picks 64 or 32 bit clocks per frame. Both selectors may change while the block runs. After a change the receiver discards the frame it was in the middle of. It then starts capturing again from the next word-select transition.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is high and after it falls, before any frame completes, `validOut` is 0 and both sample buses read 0.
- R2: With `fmtSel` = 0 (I2S), the MSB of each word arrives one bit clock after the word-select edge. Word-select low marks the left channel.
- R3: With `fmtSel` = 1 (left-justified), the MSB arrives on the first bit clock after the word-select edge, with no delay. Word-select high marks the left channel. Bits after the word are ignored.
- R4: With `fmtSel` = 2 (right-justified), the LSB is the last bit before the next word-select edge. Any leading bits in the slot are discarded. Word-select high marks the left channel.
- R5: With `ratio64` = 1 (64 bit clocks per frame, 32 per channel), all 24 bits of each word are captured.
- R6: With `ratio64` = 0 (32 bit clocks per frame, 16 per channel), 16 bits are captured into bits 23..8 of the sample, and bits 7..0 read 0.
- R7: A frame is a left slot followed by a right slot. `validOut` pulses high for exactly one clock after the right slot of a frame whose left slot was also captured.
- R8: A change of `fmtSel` or `ratio64` drops the frame in progress. No valid pulse follows in the next cycle. The first frame reported afterwards is the first one that starts after the next word-select edge.
- R9: Between valid pulses, `leftOut` and `rightOut` hold their last values, even while bit clocks keep arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| bitClkIn | input | 1 | External bit clock; data is taken on its rising edge |
| lrClkIn | input | 1 | External frame (word-select) clock |
| serDataIn | input | 1 | Serial audio data |
| fmtSel | input | 2 | 0 I2S, 1 left-justified, 2 right-justified |
| ratio64 | input | 1 | 1: 64 bit clocks per frame; 0: 32 |
| leftOut | output | 24 | Left sample of the last complete frame |
| rightOut | output | 24 | Right sample of the last complete frame |
| validOut | output | 1 | One-cycle strobe when a new frame is presented |

## Verification
Streams of three known frames are sent in each of the six format and ratio combinations. Each stream starts with a lead-in and ends with a pad frame. Junk ones fill the unused slot bits, so a word taken from the wrong position shows up, as does a word whose leading bits were not discarded or whose unused tail bits were kept. Distinct left and right words in every frame expose channel swaps. The I2S runs also separate the one-bit delay and the inverted word-select polarity from left-justified framing. Two mid-frame configuration changes, one of the ratio and one of the format, count the reported frames exactly. That count tells a receiver that drops the partial frame from one that emits it. An idle stretch with bit clocks running checks that the sample buses hold their values.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_SPARE = 2'd3
  } fmt_e;

  // strobes from control to datapath, one per system clock
  typedef struct packed {
    logic restart;   // slot boundary: start a fresh word with the current bit
    logic shiftEn;   // shift the current bit into the word
    logic capLeft;   // finished slot was left: hold it
    logic emit;      // finished slot was right with a held left: publish frame
  } strobe_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bitLvl,
  input  logic       lrLvl,
  input  logic [1:0] fmtSel,
  input  logic       ratio64,
  output strobe_t    stb,
  output logic       wideQ
);
  localparam int CNT_W = $clog2(SAMPLE_W) + 2;

  fmt_e             fmtQ;
  logic             bitQ, lrPrev, wsPrev, primed, synced, leftHave;
  logic [CNT_W-1:0] bitCnt;

  logic             bitEvt, cfgChange, isI2s, isRight, wsNow, slotEdge;
  logic [CNT_W-1:0] wordBits;

  always_comb begin
    bitEvt    = bitLvl & ~bitQ;
    cfgChange = (fmtSel != fmtQ) || (ratio64 != wideQ);
    isI2s     = (fmtQ == FMT_I2S);
    isRight   = (fmtQ == FMT_RIGHT);
    // I2S: word select seen one bit late and inverted, so left is high
    wsNow     = isI2s ? ~lrPrev : lrLvl;
    slotEdge  = bitEvt && primed && (wsNow != wsPrev);
    wordBits  = wideQ ? CNT_W'(SAMPLE_W) : CNT_W'(SHORT_W);

    stb = '0;
    if (bitEvt && !cfgChange) begin
      if (slotEdge) begin
        stb.restart = 1'b1;
        stb.capLeft = synced && wsPrev;
        stb.emit    = synced && !wsPrev && leftHave;
      end else begin
        stb.shiftEn = isRight || (bitCnt < wordBits);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitQ     <= 1'b0;
      lrPrev   <= 1'b0;
      wsPrev   <= 1'b0;
      primed   <= 1'b0;
      synced   <= 1'b0;
      leftHave <= 1'b0;
      bitCnt   <= '0;
      fmtQ     <= FMT_I2S;
      wideQ    <= 1'b1;
    end else begin
      bitQ <= bitLvl;
      if (bitEvt) begin
        lrPrev <= lrLvl;
        wsPrev <= wsNow;
        primed <= 1'b1;
      end
      if (cfgChange) begin
        fmtQ     <= fmt_e'(fmtSel);
        wideQ    <= ratio64;
        primed   <= 1'b0;
        synced   <= 1'b0;
        leftHave <= 1'b0;
      end else if (slotEdge) begin
        synced   <= 1'b1;
        leftHave <= synced && wsPrev;
        bitCnt   <= CNT_W'(1);
      end else if (bitEvt && (bitCnt != '1)) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srx_dpath.sv
module srx_dpath
  import srx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sdBit,
  input  logic                wideQ,
  input  strobe_t             stb,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                validOut
);
  localparam int PAD_W = SAMPLE_W - SHORT_W;

  logic [SAMPLE_W-1:0] shReg, leftHold, aligned;

  always_comb begin
    aligned = wideQ ? shReg : {shReg[SHORT_W-1:0], {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg    <= '0;
      leftHold <= '0;
      leftOut  <= '0;
      rightOut <= '0;
      validOut <= 1'b0;
    end else begin
      if (stb.restart)      shReg <= {{(SAMPLE_W-1){1'b0}}, sdBit};
      else if (stb.shiftEn) shReg <= {shReg[SAMPLE_W-2:0], sdBit};
      if (stb.capLeft) leftHold <= aligned;
      validOut <= stb.emit;
      if (stb.emit) begin
        leftOut  <= leftHold;
        rightOut <= aligned;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import srx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bitClkIn,
  input  logic                lrClkIn,
  input  logic                serDataIn,
  input  logic [1:0]          fmtSel,
  input  logic                ratio64,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                validOut
);
  logic [2:0] linkSync;
  strobe_t    stb;
  logic       wideQ;

  srx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bitClkIn, lrClkIn, serDataIn}),
    .q   (linkSync)
  );

  srx_ctrl #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .bitLvl  (linkSync[2]),
    .lrLvl   (linkSync[1]),
    .fmtSel  (fmtSel),
    .ratio64 (ratio64),
    .stb     (stb),
    .wideQ   (wideQ)
  );

  srx_dpath #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .sdBit    (linkSync[0]),
    .wideQ    (wideQ),
    .stb      (stb),
    .leftOut  (leftOut),
    .rightOut (rightOut),
    .validOut (validOut)
  );
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          fmtSel,
  input logic                ratio64,
  input logic [SAMPLE_W-1:0] leftOut,
  input logic [SAMPLE_W-1:0] rightOut,
  input logic                validOut
);
  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |=> !validOut);

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> ($stable(leftOut) && $stable(rightOut)));

  // R6
  short_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (validOut && !ratio64 && !$past(ratio64) && !$past(ratio64, 2))
      |-> (leftOut[7:0] == 8'h00 && rightOut[7:0] == 8'h00));

  // R8
  cfg_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ((fmtSel != $past(fmtSel)) || (ratio64 != $past(ratio64))) |=> !validOut);
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fmtSel   (fmtSel),
  .ratio64  (ratio64),
  .leftOut  (leftOut),
  .rightOut (rightOut),
  .validOut (validOut)
);

// File: tb/tb_serial_audio_rx.sv
`timescale 1ns/1ps
module tb_serial_audio_rx;
  logic        clk = 1'b0;
  logic        rst, bitClkIn, lrClkIn, serDataIn, ratio64;
  logic [1:0]  fmtSel;
  logic [23:0] leftOut, rightOut;
  logic        validOut;

  always #2 clk = ~clk;

  serial_audio_rx dut (
    .clk(clk), .rst(rst), .bitClkIn(bitClkIn), .lrClkIn(lrClkIn),
    .serDataIn(serDataIn), .fmtSel(fmtSel), .ratio64(ratio64),
    .leftOut(leftOut), .rightOut(rightOut), .validOut(validOut)
  );

  int testsRun = 0, testsFailed = 0;

  // monitor: records each valid pulse and flags pulses longer than one clock
  logic [23:0] rxL [256];
  logic [23:0] rxR [256];
  int rxCount = 0, pulseLen = 0, badPulse = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (validOut) begin
        pulseLen++;
        if (pulseLen == 1 && rxCount < 256) begin
          rxL[rxCount] = leftOut;
          rxR[rxCount] = rightOut;
          rxCount++;
        end
      end else begin
        if (pulseLen > 1) badPulse++;
        pulseLen = 0;
      end
    end
  end

  // logical stream: ws=1 is the left slot in every format before I2S mapping
  logic bWs [512];
  logic bD  [512];
  int   nBits = 0;

  task automatic chk(input string req, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkInt(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] mkWord(input int seed);
    logic [31:0] h;
    h = seed * 32'h9E3779B1;
    h = h ^ (h >> 13) ^ 32'h00A53C96;
    return h[23:0];
  endfunction

  function automatic logic [23:0] expW(input logic [23:0] w);
    return ratio64 ? w : {w[23:8], 8'h00};
  endfunction

  task automatic addSlot(input logic ws, input logic [23:0] w);
    int s = ratio64 ? 32 : 16;
    int n = ratio64 ? 24 : 16;
    for (int i = 0; i < s; i++) begin
      logic v;
      if (fmtSel == 2'd2) v = (i < s - n) ? 1'b1 : w[23 - (i - (s - n))];
      else                v = (i < n) ? w[23 - i] : 1'b1;
      bWs[nBits] = ws;
      bD[nBits]  = v;
      nBits++;
    end
  endtask

  task automatic addIdle(input int n, input logic d);
    for (int i = 0; i < n; i++) begin
      bWs[nBits] = 1'b0;
      bD[nBits]  = d;
      nBits++;
    end
  endtask

  task automatic driveBit(input logic l, input logic d);
    @(negedge clk);
    lrClkIn   = l;
    serDataIn = d;
    repeat (3) @(negedge clk);
    bitClkIn = 1'b1;
    repeat (4) @(negedge clk);
    bitClkIn = 1'b0;
  endtask

  task automatic playBits();
    for (int k = 0; k < nBits; k++) begin
      logic l;
      if (fmtSel == 2'd0) l = ~bWs[(k + 1 < nBits) ? k + 1 : k];
      else                l = bWs[k];
      driveBit(l, bD[k]);
    end
    nBits = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic setCfg(input logic [1:0] f, input logic r);
    @(negedge clk);
    fmtSel  = f;
    ratio64 = r;
  endtask

  // lead-in, preamble frame, three data frames, pad frame; checks last three
  task automatic runStream(input logic [1:0] f, input logic r, input int seed, input string req);
    int base;
    setCfg(f, r);
    base = rxCount;
    addIdle(4, 1'b0);
    addSlot(1'b1, mkWord(seed + 100));
    addSlot(1'b0, mkWord(seed + 101));
    for (int i = 0; i < 3; i++) begin
      addSlot(1'b1, mkWord(seed + 2*i));
      addSlot(1'b0, mkWord(seed + 2*i + 1));
    end
    addSlot(1'b1, 24'h0);
    addSlot(1'b0, 24'h0);
    playBits();
    chkInt(req, "enough frames", (rxCount - base >= 3) ? 1 : 0, 1);
    if (rxCount - base >= 3) begin
      for (int i = 0; i < 3; i++) begin
        int idx = rxCount - 3 + i;
        chk(req, $sformatf("frame %0d left", i),  rxL[idx], expW(mkWord(seed + 2*i)));
        chk(req, $sformatf("frame %0d right", i), rxR[idx], expW(mkWord(seed + 2*i + 1)));
      end
    end
  endtask

  // warm frame and half a garbage frame in the old setting, change mid right slot
  task automatic runResync(input logic [1:0] oldF, input logic oldR,
                           input logic [1:0] newF, input logic newR, input int seed);
    int base;
    setCfg(oldF, oldR);
    addIdle(4, 1'b0);
    addSlot(1'b1, mkWord(seed + 50));
    addSlot(1'b0, mkWord(seed + 51));
    addSlot(1'b1, mkWord(seed + 60));
    addIdle(10, 1'b1);
    playBits();
    base = rxCount;
    setCfg(newF, newR);
    addIdle(4, 1'b0);
    addSlot(1'b1, mkWord(seed + 100));
    addSlot(1'b0, mkWord(seed + 101));
    for (int i = 0; i < 3; i++) begin
      addSlot(1'b1, mkWord(seed + 2*i));
      addSlot(1'b0, mkWord(seed + 2*i + 1));
    end
    addSlot(1'b1, 24'h0);
    addSlot(1'b0, 24'h0);
    playBits();
    chkInt("R8", "frames after change", rxCount - base, 4);
    if (rxCount - base >= 1) begin
      chk("R8", "first left after change",  rxL[base], expW(mkWord(seed + 100)));
      chk("R8", "first right after change", rxR[base], expW(mkWord(seed + 101)));
    end
  endtask

  task automatic checkReset();
    chk("R1", "valid after reset", {23'h0, validOut}, 24'h0);
    chk("R1", "left after reset",  leftOut,  24'h0);
    chk("R1", "right after reset", rightOut, 24'h0);
  endtask

  task automatic checkHold();
    logic [23:0] l0, r0;
    int c0;
    runStream(2'd1, 1'b1, 700, "R3 R5");
    l0 = leftOut;
    r0 = rightOut;
    c0 = rxCount;
    addIdle(24, 1'b1);
    playBits();
    chkInt("R9", "no pulse while idle", rxCount - c0, 0);
    chk("R9", "left held",  leftOut,  l0);
    chk("R9", "right held", rightOut, r0);
    chk("R9", "left is last frame", leftOut, mkWord(704));
  endtask

  task automatic runAll();
    rst = 1'b1; bitClkIn = 1'b0; lrClkIn = 1'b0; serDataIn = 1'b0;
    fmtSel = 2'd1; ratio64 = 1'b1;
    repeat (6) @(negedge clk);
    checkReset();
    rst = 1'b0;
    repeat (5) @(negedge clk);
    checkReset();
    runStream(2'd1, 1'b1, 10, "R3 R5");
    runStream(2'd0, 1'b1, 20, "R2 R5");
    runStream(2'd2, 1'b1, 30, "R4 R5");
    runStream(2'd1, 1'b0, 40, "R3 R6");
    runStream(2'd0, 1'b0, 50, "R2 R6");
    runStream(2'd2, 1'b0, 60, "R4 R6");
    checkHold();
    runResync(2'd1, 1'b1, 2'd1, 1'b0, 300);
    runResync(2'd2, 1'b1, 2'd1, 1'b1, 400);
    chkInt("R7", "pulses wider than one clock", badPulse, 0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        testsFailed++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule